// File: doc/BRIEF.md
# Cascadable Four-Bit Arithmetic and Logic Slice

This block is a combinational arithmetic and logic slice that works on two 4-bit operands, R and S. A 3-bit operation select picks one of eight functions. Three are two's-complement arithmetic operations that use the carry input: a sum and two differences, one for each subtraction order. The other five are bitwise logic functions, and one of them inverts the R operand. There is no clock and no state. Every output follows the present inputs.

The slice is meant to be used as a bit slice in a wider datapath. Its carry output can drive the carry input of the next slice. It also exports a group carry-propagate and a group carry-generate signal, so that a separate look-ahead unit can work out the carries of many slices in parallel without waiting for the ripple. Two slices chained carry output to carry input make an 8-bit unit.

Top module: `bitslice_alu`

## Requirements
- R1: With op_sel = 3'b000, result = (opnd_r + opnd_s + carry_in) mod 16.
- R2: With op_sel = 3'b001 the slice computes S minus R as opnd_s + ~opnd_r + carry_in. With op_sel = 3'b010 it computes R minus S as opnd_r + ~opnd_s + carry_in. In both cases the result is the low 4 bits, and with carry_in = 1 it is the exact two's-complement difference.
- R3: The logic encodings are 3'b011 OR, 3'b100 AND, 3'b101 (NOT R) AND S, 3'b110 XOR and 3'b111 XNOR. For these, carry_in has no effect on result.
- R4: For the arithmetic encodings, carry_out is bit 4 of the 5-bit sum of the two adder operands and carry_in. For the logic encodings, carry_out is 0.
- R5: For the arithmetic encodings, overflow is the XOR of the carry into bit 3 and the carry out of bit 3. For the logic encodings, overflow is 0.
- R6: The adder operands are opnd_r with every bit inverted when op_sel = 001, and opnd_s with every bit inverted when op_sel = 010. For every other code, both operands are used as they are. grp_prop is 1 exactly when every bit position has at least one adder-operand bit set.
- R7: grp_gen is the carry out of bit 3 when the two adder operands are added with a carry input of 0. Whenever grp_gen is 1 on an arithmetic code, carry_out is 1.
- R8: Two slices, with the carry_out of the low slice driving the carry_in of the high slice, give the correct 8-bit result for every code. The high slice's carry_out and overflow are then the 8-bit carry and the 8-bit signed overflow.
- R9: The slice has no clock and no state. Outputs settle to the function of the current inputs within the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_r | input | 4 | Operand R |
| opnd_s | input | 4 | Operand S |
| carry_in | input | 1 | Carry into bit 0 |
| op_sel | input | 3 | Function select |
| result | output | 4 | Function result |
| carry_out | output | 1 | Carry out of bit 3, 0 for logic codes |
| overflow | output | 1 | Signed overflow, 0 for logic codes |
| grp_prop | output | 1 | Group carry-propagate |
| grp_gen | output | 1 | Group carry-generate |

## Verification
The situations that are hardest to reach are the signed-overflow corners of the two subtraction orders and the cases where a carry crosses between chained slices. These need a specific mix of operand signs and carry_in. The stimulus therefore walks all 4096 combinations of the two operands, carry_in and the function code on a single slice. It then sweeps a two-slice chain over a spread of 8-bit operand pairs, for every code and both carry_in values. This exercises every path where the low slice's carry changes the high slice's result and its overflow.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 3'b000,
    OP_SUBSR = 3'b001,
    OP_SUBRS = 3'b010,
    OP_OR    = 3'b011,
    OP_AND   = 3'b100,
    OP_NRAND = 3'b101,
    OP_XOR   = 3'b110,
    OP_XNOR  = 3'b111
  } alu_op_e;

  function automatic logic op_is_arith(input logic [OP_W-1:0] code);
    return (code == OP_ADD) || (code == OP_SUBSR) || (code == OP_SUBRS);
  endfunction
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu4_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]    in_r,
  input  logic [W-1:0]    in_s,
  input  logic [OP_W-1:0] code,
  output logic [W-1:0]    add_a,
  output logic [W-1:0]    add_b
);
  logic inv_r;
  logic inv_s;

  assign inv_r = (code == OP_SUBSR);
  assign inv_s = (code == OP_SUBRS);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign add_a[i] = in_r[i] ^ inv_r;
    assign add_b[i] = in_s[i] ^ inv_s;
  end
endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] add_a,
  input  logic [W-1:0] add_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf,
  output logic         gp,
  output logic         gg
);
  logic [W-1:0] bit_p;
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_x;
  logic [W:0]   carry;
  logic [W:0]   grp_p_acc;
  logic [W:0]   grp_g_acc;

  for (genvar i = 0; i < W; i++) begin : g_pg
    assign bit_p[i] = add_a[i] | add_b[i];
    assign bit_g[i] = add_a[i] & add_b[i];
    assign bit_x[i] = add_a[i] ^ add_b[i];
  end

  // Each carry is computed from the carry input in look-ahead form.
  assign carry[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_carry
    logic [i+1:0] terms;
    assign terms[0] = bit_g[i];
    for (genvar j = 0; j < i; j++) begin : g_term
      assign terms[j+1] = bit_g[j] & (&bit_p[i:j+1]);
    end
    assign terms[i+1] = cin & (&bit_p[i:0]);
    assign carry[i+1] = |terms;
  end

  for (genvar i = 0; i < W; i++) begin : g_sum
    assign sum[i] = bit_x[i] ^ carry[i];
  end

  // The group terms are folded from the low bit upwards.
  assign grp_p_acc[0] = 1'b1;
  assign grp_g_acc[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_group
    assign grp_p_acc[i+1] = grp_p_acc[i] & bit_p[i];
    assign grp_g_acc[i+1] = bit_g[i] | (bit_p[i] & grp_g_acc[i]);
  end

  assign gp   = grp_p_acc[W];
  assign gg   = grp_g_acc[W];
  assign cout = carry[W];
  assign ovf  = carry[W] ^ carry[W-1];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu4_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]    in_r,
  input  logic [W-1:0]    in_s,
  input  logic [OP_W-1:0] code,
  output logic [W-1:0]    lres
);
  always_comb begin
    unique case (alu_op_e'(code))
      OP_OR:    lres = in_r | in_s;
      OP_AND:   lres = in_r & in_s;
      OP_NRAND: lres = ~in_r & in_s;
      OP_XOR:   lres = in_r ^ in_s;
      OP_XNOR:  lres = ~(in_r ^ in_s);
      default:  lres = '0;
    endcase
  end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
  import alu4_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] opnd_r,
  input  logic [WIDTH-1:0] opnd_s,
  input  logic             carry_in,
  input  logic [OP_W-1:0]  op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow,
  output logic             grp_prop,
  output logic             grp_gen
);
  logic [WIDTH-1:0] add_a;
  logic [WIDTH-1:0] add_b;
  logic [WIDTH-1:0] sum_w;
  logic [WIDTH-1:0] logic_w;
  logic             cout_w;
  logic             ovf_w;
  logic             arith;

  assign arith = op_is_arith(op_sel);

  alu_operand_prep #(.W(WIDTH)) u_prep (
    .in_r  (opnd_r),
    .in_s  (opnd_s),
    .code  (op_sel),
    .add_a (add_a),
    .add_b (add_b)
  );

  alu_carry_chain #(.W(WIDTH)) u_chain (
    .add_a (add_a),
    .add_b (add_b),
    .cin   (carry_in),
    .sum   (sum_w),
    .cout  (cout_w),
    .ovf   (ovf_w),
    .gp    (grp_prop),
    .gg    (grp_gen)
  );

  alu_logic_unit #(.W(WIDTH)) u_logic (
    .in_r  (opnd_r),
    .in_s  (opnd_s),
    .code  (op_sel),
    .lres  (logic_w)
  );

  assign result    = arith ? sum_w : logic_w;
  assign carry_out = arith & cout_w;
  assign overflow  = arith & ovf_w;
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk
  import alu4_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input logic [W-1:0]    opnd_r,
  input logic [W-1:0]    opnd_s,
  input logic            carry_in,
  input logic [OP_W-1:0] op_sel,
  input logic [W-1:0]    result,
  input logic            carry_out,
  input logic            overflow,
  input logic            grp_prop,
  input logic            grp_gen
);
  logic arith_c;
  assign arith_c = (op_sel == 3'b000) || (op_sel == 3'b001) || (op_sel == 3'b010);

  always_comb begin
    // R4
    logic_cout_chk: assert (arith_c || !carry_out)
      else $error("carry_out set on logic code");
    // R5
    logic_ovf_chk: assert (arith_c || !overflow)
      else $error("overflow set on logic code");
    // R7
    gen_forces_carry_chk: assert (!(arith_c && grp_gen) || carry_out)
      else $error("group generate without carry_out");
    // R6
    no_prop_no_carry_chk: assert (!(arith_c && !grp_prop && !grp_gen) || !carry_out)
      else $error("carry_out without propagate or generate");
    // R5
    add_ovf_sign_chk: assert (op_sel != 3'b000 ||
      overflow == ((opnd_r[W-1] == opnd_s[W-1]) && (result[W-1] != opnd_r[W-1])))
      else $error("add overflow disagrees with sign rule");
  end
endmodule

bind bitslice_alu bitslice_alu_chk #(.W(WIDTH)) u_chk (
  .opnd_r    (opnd_r),
  .opnd_s    (opnd_s),
  .carry_in  (carry_in),
  .op_sel    (op_sel),
  .result    (result),
  .carry_out (carry_out),
  .overflow  (overflow),
  .grp_prop  (grp_prop),
  .grp_gen   (grp_gen)
);

// File: tb/test_bitslice_alu.sv
module test_bitslice_alu;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [3:0] r4, s4;
  logic       ci4;
  logic [2:0] op;
  logic [3:0] f4;
  logic       co4, ov4, gp4, gg4;

  bitslice_alu i_bitslice_alu (
    .opnd_r(r4), .opnd_s(s4), .carry_in(ci4), .op_sel(op),
    .result(f4), .carry_out(co4), .overflow(ov4),
    .grp_prop(gp4), .grp_gen(gg4)
  );

  logic [7:0] r8, s8, f8;
  logic       ci8, c_mid, co8, ov8, ov_lo;
  logic       gp_lo, gg_lo, gp_hi, gg_hi;

  bitslice_alu i_lo (
    .opnd_r(r8[3:0]), .opnd_s(s8[3:0]), .carry_in(ci8), .op_sel(op),
    .result(f8[3:0]), .carry_out(c_mid), .overflow(ov_lo),
    .grp_prop(gp_lo), .grp_gen(gg_lo)
  );
  bitslice_alu i_hi (
    .opnd_r(r8[7:4]), .opnd_s(s8[7:4]), .carry_in(c_mid), .op_sel(op),
    .result(f8[7:4]), .carry_out(co8), .overflow(ov8),
    .grp_prop(gp_hi), .grp_gen(gg_hi)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h (op=%0d r=%0h s=%0h cin=%0b)",
               tag, act, exp, op, r4, s4, ci4);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Behavioural model of one arithmetic/logic operation at a given width.
  task automatic model(input int w, input int r, input int s, input int ci, input int code,
                       output int f, output int co, output int ov, output int gp, output int gg);
    int mask, a, b, tot, low, cin_top;
    mask = (1 << w) - 1;
    a = (code == 1) ? (~r & mask) : r;
    b = (code == 2) ? (~s & mask) : s;
    tot = a + b + ci;
    low = ((a & (mask >> 1)) + (b & (mask >> 1)) + ci) >> (w - 1);
    cin_top = low & 1;
    gp = ((a | b) == mask) ? 1 : 0;
    gg = ((a + b) >> w) & 1;
    if (code <= 2) begin
      f  = tot & mask;
      co = (tot >> w) & 1;
      ov = co ^ cin_top;
    end else begin
      co = 0; ov = 0;
      case (code)
        3: f = r | s;
        4: f = r & s;
        5: f = ~r & s & mask;
        6: f = r ^ s;
        default: f = ~(r ^ s) & mask;
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int ef, eco, eov, egp, egg;
    r4 = '0; s4 = '0; ci4 = 1'b0; op = '0;
    r8 = '0; s8 = '0; ci8 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #2;
    // Idle state with all-zero inputs: R1 sum 0, R7 no generate, R6 no propagate
    check("R1 idle result", int'(f4), 0);
    check("R4 idle carry", int'(co4), 0);
    check("R6 idle prop", int'(gp4), 0);
    check("R7 idle gen", int'(gg4), 0);

    // Exhaustive single-slice sweep
    for (int code = 0; code < 8; code++)
      for (int ci = 0; ci < 2; ci++)
        for (int r = 0; r < 16; r++)
          for (int s = 0; s < 16; s++) begin
            @(posedge clk);
            op = code[2:0]; ci4 = ci[0]; r4 = r[3:0]; s4 = s[3:0];
            #2; // R9: outputs follow in the same cycle
            model(4, r, s, ci, code, ef, eco, eov, egp, egg);
            if (code == 0)      check("R1 result", int'(f4), ef);
            else if (code <= 2) check("R2 result", int'(f4), ef);
            else                check("R3 result", int'(f4), ef);
            check("R4 carry_out", int'(co4), eco);
            check("R5 overflow", int'(ov4), eov);
            check("R6 grp_prop", int'(gp4), egp);
            check("R7 grp_gen", int'(gg4), egg);
          end

    // Two-slice 8-bit chain: R8
    for (int code = 0; code < 8; code++)
      for (int ci = 0; ci < 2; ci++)
        for (int r = 0; r < 256; r += 3)
          for (int s = 0; s < 256; s += 7) begin
            @(posedge clk);
            op = code[2:0]; ci8 = ci[0]; r8 = r[7:0]; s8 = s[7:0];
            #2;
            model(8, r, s, ci, code, ef, eco, eov, egp, egg);
            check("R8 chain result", int'(f8), ef);
            check("R8 chain carry", int'(co8), eco);
            check("R8 chain overflow", int'(ov8), eov);
          end

    done = 1'b1;
    summary();
  end
endmodule